// File: doc/BRIEF.md
# Serial Management Frame Master

This block is the master side of a two-wire PHY management link. A host asks for a register read or a register write. It gives a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block builds the whole serial frame and produces the management clock from the system clock through a fixed divider. It shifts every bit out, or releases the line and collects the answer. When the frame is finished it lowers busy and raises done for one cycle.

The shared data pin is modelled as three separate signals: an output value, an output enable and an input. The line is released outside a frame. After the data field of every frame, the master drives the line low for two extra clock periods. On a write, the master drives the turnaround bits itself.

Top module: `mdio_master`

## Requirements
- R1: A frame starts with 32 bits of one, followed by the start pattern 0 then 1.
- R2: The 2-bit opcode follows the start pattern: 0 then 1 for a write, 1 then 0 for a read.
- R3: After the opcode come the PHY address and then the register address, each 5 bits and sent most significant bit first.
- R4: On a write, the master drives the turnaround as 1 then 0. It then sends the 16 data bits, most significant bit first, with the output enable high on every bit of the frame.
- R5: On a read, the output enable is low for the 2 turnaround bits and the 16 data bits. The line is sampled on each rising management clock during the data bits, most significant bit first. The word is presented on rdata when done rises and held until the next read completes.
- R6: After the data field, every frame has two more clock periods with the output value 0 and the output enable 1.
- R7: The output value and output enable change only while the management clock is low. Both are stable across each rising edge and for the whole high phase.
- R8: A request is taken only when busy is low. A request made while busy is high does not change the frame in progress or its length.
- R9: Busy goes high in the cycle after a request is accepted. It stays high for exactly 132 x HALF_DIV system cycles (66 bit periods). Done is high for exactly one system cycle, in the cycle busy falls.
- R10: The management clock period is 2 x HALF_DIV system cycles, with a low phase then a high phase of HALF_DIV cycles each. Outside a frame, and from reset, the clock is low, the output enable is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Start a frame (taken only when busy is low) |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Value to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Data line output value |
| mdo_oe | output | 1 | Data line output enable |
| mdi | input | 1 | Data line input |

## Verification
The bench records every bit on the wire at the rising management clock. It compares each field with a frame built from the requirements. A bit-order or field-order mistake therefore shows up as a wrong address or opcode field. A read sampled on the wrong edge or one bit late returns a shifted word. The bench also checks the two trailing low clocks and the write turnaround polarity: a design that skips the trailer ends the frame 2 bit periods early, and one that releases the line during a write turnaround shows a low enable. A burst of conflicting requests in the middle of a frame checks that a design which restarts or reloads corrupts neither the frame bits nor the busy length.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 16;
  localparam int TAIL_BITS  = 2;
  localparam int HEAD_BITS  = PRE_BITS + 2 + 2 + 2 * ADDR_BITS;       // 46
  localparam int RD_FIRST   = HEAD_BITS + 2;                          // 48
  localparam int FRAME_BITS = RD_FIRST + DATA_BITS + TAIL_BITS;       // 66

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } opcode_e;

  // Wire values, first bit sent in the MSB.
  function automatic frame_t build_bits(input logic wr,
                                        input logic [ADDR_BITS-1:0] phy,
                                        input logic [ADDR_BITS-1:0] regad,
                                        input logic [DATA_BITS-1:0] wdata);
    opcode_e op;
    logic [1:0] ta;
    op = wr ? OPC_WRITE : OPC_READ;
    ta = wr ? 2'b10 : 2'b00;
    return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta,
            (wr ? wdata : {DATA_BITS{1'b0}}), {TAIL_BITS{1'b0}}};
  endfunction

  // Output enable per bit, first bit in the MSB.
  function automatic frame_t build_oe(input logic wr);
    return {{HEAD_BITS{1'b1}}, {(2 + DATA_BITS){wr}}, {TAIL_BITS{1'b1}}};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV) + 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_bitseq.sv
module mdio_bitseq #(
  parameter int NBITS = 66
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     tick,
  output logic                     phase_hi,
  output logic [$clog2(NBITS)-1:0] bit_idx,
  output logic                     last_bit
);
  localparam int IW = $clog2(NBITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      phase_hi <= 1'b0;
      bit_idx  <= '0;
    end else if (tick) begin
      phase_hi <= !phase_hi;
      if (phase_hi && bit_idx != LAST_IDX) begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign last_bit = (bit_idx == LAST_IDX);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdc,
  output logic        mdo,
  output logic        mdo_oe,
  input  logic        mdi
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] RD_LO = IW'(RD_FIRST);
  localparam logic [IW-1:0] RD_HI = IW'(RD_FIRST + DATA_BITS - 1);

  logic          accept, tick, phase_hi, last_bit;
  logic          rise_now, fall_now;
  logic [IW-1:0] bit_idx;
  frame_t        tx_sh, oe_sh, ld_bits, ld_oe;
  logic [DATA_BITS-1:0] rx_sh;
  logic          is_rd;

  assign accept   = req && !busy;
  assign rise_now = tick && !phase_hi;
  assign fall_now = tick && phase_hi;
  assign ld_bits  = build_bits(req_write, req_phy, req_reg, req_wdata);
  assign ld_oe    = build_oe(req_write);

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (tick)
  );

  mdio_bitseq #(.NBITS(FRAME_BITS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .tick     (tick),
    .phase_hi (phase_hi),
    .bit_idx  (bit_idx),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      mdc    <= 1'b0;
      mdo    <= 1'b0;
      mdo_oe <= 1'b0;
      tx_sh  <= '0;
      oe_sh  <= '0;
      rx_sh  <= '0;
      rdata  <= '0;
      is_rd  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        is_rd  <= !req_write;
        mdc    <= 1'b0;
        mdo    <= ld_bits[FRAME_BITS-1];
        mdo_oe <= ld_oe[FRAME_BITS-1];
        tx_sh  <= ld_bits << 1;
        oe_sh  <= ld_oe << 1;
      end else if (rise_now) begin
        mdc <= 1'b1;
        if (is_rd && bit_idx >= RD_LO && bit_idx <= RD_HI) begin
          rx_sh <= {rx_sh[DATA_BITS-2:0], mdi};
        end
      end else if (fall_now) begin
        mdc <= 1'b0;
        if (last_bit) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          mdo    <= 1'b0;
          mdo_oe <= 1'b0;
          if (is_rd) begin
            rdata <= rx_sh;
          end
        end else begin
          mdo    <= tx_sh[FRAME_BITS-1];
          mdo_oe <= oe_sh[FRAME_BITS-1];
          tx_sh  <= tx_sh << 1;
          oe_sh  <= oe_sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic req,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdo,
  input logic mdo_oe
);
  p_hold_high_r7: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdo_oe)));

  p_rise_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdo) && $stable(mdo_oe)));

  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_idle_clk_low_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdo_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .busy   (busy),
  .done   (done),
  .mdc    (mdc),
  .mdo    (mdo),
  .mdo_oe (mdo_oe)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int HALF = 3;
  localparam int NB   = 66;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, mdc, mdo, mdo_oe, mdi;
  logic [15:0] rdata;

  always #10 clk = ~clk;  // 50 MHz

  mdio_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata),
    .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  int checks = 0, fails = 0;
  int rises = 0, busy_cnt = 0, done_cnt = 0, cyc = 0, last_rise = 0;
  bit per_bad = 0;
  logic prev_mdc = 1'b0;
  logic [NB-1:0] cap_d = '0, cap_oe = '0;
  logic [15:0] resp = '0;

  // PHY model: drives the read word during bits 48..63, else line pulled up.
  assign mdi = (rises >= 48 && rises < 64) ? resp[63 - rises] : 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (done) done_cnt++;
    if (mdc && !prev_mdc) begin
      if (rises < NB) begin
        cap_d[NB-1-rises]  = mdo;
        cap_oe[NB-1-rises] = mdo_oe;
      end
      if (rises > 0 && (cyc - last_rise) != 2 * HALF) per_bad = 1;
      last_rise = cyc;
      rises++;
    end
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [15:0] rs,
                           input bit poke);
    logic [NB-1:0] ed, eo;
    int t;
    ed = {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
          (w ? {2'b10, d} : 18'd0), 2'b00};
    eo = w ? {NB{1'b1}} : {{46{1'b1}}, 18'd0, 2'b11};
    @(negedge clk);
    resp = rs; rises = 0; busy_cnt = 0; done_cnt = 0; per_bad = 0;
    cap_d = '0; cap_oe = '0;
    req = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req = 1'b0; req_wdata = ~d;
    if (poke) begin
      repeat (100) @(negedge clk);
      req = 1'b1; req_write = !w; req_phy = ~p; req_reg = ~r;
      repeat (20) @(negedge clk);
      req = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    // R1 preamble and start pattern
    check(cap_d[65:32] == ed[65:32], "R1 preamble/start", cap_d, ed);
    // R2 opcode
    check(cap_d[31:30] == ed[31:30], "R2 opcode", cap_d, ed);
    // R3 addresses
    check(cap_d[29:20] == ed[29:20], "R3 phy/reg address", cap_d, ed);
    if (w) begin
      // R4 turnaround 1,0 then data, enable high throughout
      check(cap_d[19:2] == ed[19:2], "R4 write turnaround/data", cap_d, ed);
      check(cap_oe == eo, "R4 write enable", cap_oe, eo);
    end else begin
      // R5 released line and sampled word
      check(cap_oe == eo, "R5 read enable", cap_oe, eo);
      check(rdata == rs, "R5 read data", {50'd0, rdata}, {50'd0, rs});
    end
    // R6 trailing clocks
    check(cap_d[1:0] == 2'b00 && cap_oe[1:0] == 2'b11, "R6 trailer",
          {62'd0, cap_d[1:0], cap_oe[1:0]}, 66'h3);
    // R9 busy length and done pulse
    check(busy_cnt == 132 * HALF, "R9 busy length", NB'(busy_cnt), NB'(132 * HALF));
    check(done_cnt == 1, "R9 done pulse", NB'(done_cnt), NB'(1));
    // R10 clock period, bit count, idle low
    check(!per_bad && rises == NB && !mdc && !mdo_oe, "R10 clock",
          NB'(rises), NB'(NB));
    if (poke) check(busy_cnt == 132 * HALF && cap_d[31:20] == ed[31:20],
                    "R8 request while busy", cap_d, ed);
  endtask

  localparam bit [42:0] VEC [5] = '{
    {1'b1, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b0, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
    {1'b1, 5'h10, 5'h01, 16'hFFFF, 16'h0000},
    {1'b0, 5'h00, 5'h00, 16'h0000, 16'h8001},
    {1'b1, 5'h15, 5'h0A, 16'h0000, 16'h0000}
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !mdc && !mdo_oe, "R10 reset state",
          {62'd0, busy, done, mdc, mdo_oe}, 66'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !mdc && rdata == 16'h0, "R10 idle after reset",
          {49'd0, busy, rdata}, 66'd0);
    foreach (VEC[i]) begin
      run_frame(VEC[i][42], VEC[i][41:37], VEC[i][36:32],
                VEC[i][31:16], VEC[i][15:0], 1'b0);
    end
    // R8 directed: conflicting requests mid-frame, read then write
    run_frame(1'b0, 5'h0C, 5'h13, 16'h0000, 16'h5A0F, 1'b1);
    run_frame(1'b1, 5'h03, 5'h1C, 16'hC0DE, 16'h0000, 1'b1);
    // R5 rdata held through a following write
    check(rdata == 16'h5A0F, "R5 rdata held", {50'd0, rdata}, {50'd0, 16'h5A0F});
    finish_run();
  end
endmodule